// File: doc/BRIEF.md
# Column-Strip Monochrome Frame Buffer

This block holds one image for a 128 by 64 single-colour display. The image sits in 1024 bytes, and each byte covers a vertical run of eight pixels in one column. A drawing client changes one pixel at a time by giving an (x, y) position and an operation. The block then reads the byte that holds that pixel, changes one bit and writes the byte back. A fill command overwrites the whole image with one byte value.

A second port feeds the stored bytes, in the order the panel scans them, to a downstream serial display driver through a valid/ready handshake. The driver pulls bytes whenever it has room. When the driver runs without pause it gets one byte per cycle. The byte offered is held steady until the driver takes it.

Top module: `strip_framebuffer`

## Requirements
- R1: A pixel at column x (0..127) and row y (0..63) is stored in byte index (y/8)*128 + x, at bit y%8. Bit 0 is the top pixel of the eight-pixel run, and a stored 1 means the pixel is lit.
- R2: `px_op` selects the edit: 0 sets the bit, 1 clears it, 2 inverts it, and 3 leaves it unchanged.
- R3: A pixel command is taken only in a cycle where `px_valid` is high, `busy` is low and `clr_start` is low. Once taken, `busy` is high for exactly the next two cycles (read, then write). A command offered while `busy` is high has no effect.
- R4: A pixel edit leaves the other seven bits of the target byte unchanged.
- R5: `clr_start` while `busy` is low starts a fill, and it wins over a pixel command offered in the same cycle. The fill writes `clr_fill` to all 1024 bytes, holds `busy` high for exactly 1024 cycles, and ignores any pixel command that arrives during it.
- R6: When a fill is taken, `st_valid` drops in the next cycle and stays low while the fill runs. After the fill, the first byte offered carries index 0.
- R7: Bytes are offered in index order 0, 1, ..., 1023 and then wrap back to 0. The offered index moves on only after a handshake (`st_valid` and `st_ready` both high).
- R8: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_data` and `st_index` stay unchanged.
- R9: If a pixel write lands on the byte that the stream is about to fetch in the same cycle, the write goes first and the fetch waits one cycle. The byte offered then carries the written value.
- R10: While `rst` is high, `busy` and `st_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Pixel command offered |
| px_x | input | 7 | Pixel column |
| px_y | input | 6 | Pixel row |
| px_op | input | 2 | Edit code: 0 set, 1 clear, 2 invert, 3 none |
| clr_start | input | 1 | Start a fill of the whole image |
| clr_fill | input | 8 | Byte value written by a fill |
| busy | output | 1 | An edit or a fill is running |
| st_valid | output | 1 | Stream byte available |
| st_data | output | 8 | Stream byte |
| st_index | output | 10 | Index of the stream byte |
| st_ready | input | 1 | Downstream takes the byte |

## Verification
The bench targets the mapping corners: the last byte (x=127, y=63 → byte 1023, bit 7), rows that sit on either side of a page boundary, and edits stacked on one byte. Getting the mapping wrong would put pixels in the wrong column or strip. Getting the masking wrong would disturb the neighbouring bits. It also targets a write that lands on the exact byte the stream fetches in the same cycle. A design without the stall would send the old byte. Other targets are a pixel command offered at the same time as a fill, or during one, and a ready line that drops out at irregular points. A design that mishandles priority would corrupt the filled image. One that mishandles the hold would skip or repeat bytes, or change a byte that has not yet been taken. The bench also follows the stream across the wrap from index 1023 to 0 and checks the restart at index 0 after a fill.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam int STRIP_W = 8;
    localparam int STRIP_SEL_W = $clog2(STRIP_W);

    typedef enum logic [1:0] {
        PIX_SET   = 2'd0,
        PIX_CLEAR = 2'd1,
        PIX_FLIP  = 2'd2,
        PIX_KEEP  = 2'd3
    } pix_op_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_READ,
        ENG_WRITE,
        ENG_FILL
    } eng_state_e;

    typedef struct packed {
        logic [STRIP_SEL_W-1:0] bit_sel;
        pix_op_e                op;
    } strip_edit_t;

    function automatic logic [STRIP_W-1:0] apply_edit(
        input logic [STRIP_W-1:0] cur,
        input strip_edit_t        ed
    );
        logic [STRIP_W-1:0] mask;
        mask = STRIP_W'(1) << ed.bit_sel;
        case (ed.op)
            PIX_SET:   return cur | mask;
            PIX_CLEAR: return cur & ~mask;
            PIX_FLIP:  return cur ^ mask;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/sfb_store.sv
module sfb_store #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_edit,
    output logic [DW-1:0] rdata_edit,
    input  logic [AW-1:0] raddr_scan,
    output logic [DW-1:0] rdata_scan
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_edit = cells[raddr_edit];
    assign rdata_scan = cells[raddr_scan];
endmodule

// File: rtl/sfb_draw_engine.sv
module sfb_draw_engine
    import sfb_pkg::*;
#(
    parameter int COLS  = 128,
    parameter int ROWS  = 64,
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int XW    = 7,
    parameter int YW    = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               px_valid,
    input  logic [XW-1:0]      px_x,
    input  logic [YW-1:0]      px_y,
    input  logic [1:0]         px_op,
    input  logic               clr_start,
    input  logic [STRIP_W-1:0] clr_fill,
    output logic               busy,
    output logic               fill_go,
    output logic               filling,
    output logic [AW-1:0]      rd_addr,
    input  logic [STRIP_W-1:0] rd_data,
    output logic               wr_en,
    output logic [AW-1:0]      wr_addr,
    output logic [STRIP_W-1:0] wr_data
);
    eng_state_e         state;
    logic [AW-1:0]      addr_q;
    strip_edit_t        edit_q;
    logic [STRIP_W-1:0] byte_q;
    logic [STRIP_W-1:0] fill_q;
    logic [AW-1:0]      fill_idx;
    logic [AW-1:0]      target_idx;
    strip_edit_t        edit_d;

    // page = y / strip height; byte = page * COLS + x
    assign target_idx = AW'(px_y >> STRIP_SEL_W) * AW'(COLS) + AW'(px_x);
    assign edit_d.bit_sel = px_y[STRIP_SEL_W-1:0];
    assign edit_d.op      = pix_op_e'(px_op);

    assign busy    = (state != ENG_IDLE);
    assign fill_go = (state == ENG_IDLE) && clr_start;
    assign filling = (state == ENG_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            addr_q   <= '0;
            edit_q   <= '0;
            byte_q   <= '0;
            fill_q   <= '0;
            fill_idx <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (clr_start) begin
                        fill_q   <= clr_fill;
                        fill_idx <= '0;
                        state    <= ENG_FILL;
                    end else if (px_valid) begin
                        addr_q <= target_idx;
                        edit_q <= edit_d;
                        state  <= ENG_READ;
                    end
                end
                ENG_READ: begin
                    byte_q <= apply_edit(rd_data, edit_q);
                    state  <= ENG_WRITE;
                end
                ENG_WRITE: begin
                    state <= ENG_IDLE;
                end
                ENG_FILL: begin
                    fill_idx <= fill_idx + 1'b1;
                    if (fill_idx == AW'(DEPTH - 1)) begin
                        state <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_addr = addr_q;
        wr_en   = (state == ENG_WRITE) || (state == ENG_FILL);
        wr_addr = (state == ENG_FILL) ? fill_idx : addr_q;
        wr_data = (state == ENG_FILL) ? fill_q : byte_q;
    end
endmodule

// File: rtl/sfb_stream.sv
module sfb_stream
    import sfb_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               hold,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    output logic [AW-1:0]      fetch_addr,
    input  logic [STRIP_W-1:0] fetch_data,
    input  logic               st_ready,
    output logic               st_valid,
    output logic [STRIP_W-1:0] st_data,
    output logic [AW-1:0]      st_index
);
    logic          slot_free;
    logic          collide;
    logic [AW-1:0] next_addr;

    assign slot_free = !st_valid || st_ready;
    assign collide   = wr_en && (wr_addr == fetch_addr);
    assign next_addr = (fetch_addr == AW'(DEPTH - 1)) ? '0 : fetch_addr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_addr <= '0;
            st_valid   <= 1'b0;
            st_data    <= '0;
            st_index   <= '0;
        end else if (restart) begin
            fetch_addr <= '0;
            st_valid   <= 1'b0;
        end else if (!hold && slot_free) begin
            if (collide) begin
                st_valid <= 1'b0;
            end else begin
                st_data    <= fetch_data;
                st_index   <= fetch_addr;
                st_valid   <= 1'b1;
                fetch_addr <= next_addr;
            end
        end
    end
endmodule

// File: rtl/strip_framebuffer.sv
module strip_framebuffer
    import sfb_pkg::*;
#(
    parameter int COLS = 128,
    parameter int ROWS = 64
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               px_valid,
    input  logic [$clog2(COLS)-1:0]            px_x,
    input  logic [$clog2(ROWS)-1:0]            px_y,
    input  logic [1:0]                         px_op,
    input  logic                               clr_start,
    input  logic [7:0]                         clr_fill,
    output logic                               busy,
    output logic                               st_valid,
    output logic [7:0]                         st_data,
    output logic [$clog2(COLS*ROWS/8)-1:0]     st_index,
    input  logic                               st_ready
);
    localparam int PAGES = ROWS / STRIP_W;
    localparam int DEPTH = COLS * PAGES;
    localparam int AW    = $clog2(DEPTH);
    localparam int XW    = $clog2(COLS);
    localparam int YW    = $clog2(ROWS);

    logic               fill_go;
    logic               filling;
    logic [AW-1:0]      edit_raddr;
    logic [STRIP_W-1:0] edit_rdata;
    logic [AW-1:0]      scan_raddr;
    logic [STRIP_W-1:0] scan_rdata;
    logic               wr_en;
    logic [AW-1:0]      wr_addr;
    logic [STRIP_W-1:0] wr_data;

    sfb_store #(.DEPTH(DEPTH), .AW(AW), .DW(STRIP_W)) u_store (
        .clk        (clk),
        .we         (wr_en),
        .waddr      (wr_addr),
        .wdata      (wr_data),
        .raddr_edit (edit_raddr),
        .rdata_edit (edit_rdata),
        .raddr_scan (scan_raddr),
        .rdata_scan (scan_rdata)
    );

    sfb_draw_engine #(
        .COLS(COLS), .ROWS(ROWS), .DEPTH(DEPTH), .AW(AW), .XW(XW), .YW(YW)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .px_valid  (px_valid),
        .px_x      (px_x),
        .px_y      (px_y),
        .px_op     (px_op),
        .clr_start (clr_start),
        .clr_fill  (clr_fill),
        .busy      (busy),
        .fill_go   (fill_go),
        .filling   (filling),
        .rd_addr   (edit_raddr),
        .rd_data   (edit_rdata),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    sfb_stream #(.DEPTH(DEPTH), .AW(AW)) u_stream (
        .clk        (clk),
        .rst        (rst),
        .restart    (fill_go),
        .hold       (filling),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .fetch_addr (scan_raddr),
        .fetch_data (scan_rdata),
        .st_ready   (st_ready),
        .st_valid   (st_valid),
        .st_data    (st_data),
        .st_index   (st_index)
    );
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          px_valid,
    input logic          clr_start,
    input logic          busy,
    input logic          st_valid,
    input logic [7:0]    st_data,
    input logic [AW-1:0] st_index,
    input logic          st_ready
);
    logic          clr_run;
    logic [AW:0]   clr_cnt;
    logic          fill_take;

    assign fill_take = clr_start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_run <= 1'b0;
            clr_cnt <= '0;
        end else if (fill_take) begin
            clr_run <= 1'b1;
            clr_cnt <= '0;
        end else if (clr_run) begin
            if (busy) clr_cnt <= clr_cnt + 1'b1;
            else      clr_run <= 1'b0;
        end
    end

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready && !fill_take)
        |=> (st_valid && $stable(st_data) && $stable(st_index)));

    a_r7_index_step: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready && !fill_take)
        |=> (!st_valid || st_index == (($past(st_index) == AW'(DEPTH - 1)) ? '0 : $past(st_index) + 1'b1)));

    a_r3_edit_two_cycles: assert property (@(posedge clk) disable iff (rst)
        (px_valid && !busy && !clr_start) |=> busy ##1 busy ##1 !busy);

    a_r5_fill_length: assert property (@(posedge clk) disable iff (rst)
        (clr_run && !busy) |-> (clr_cnt == (AW+1)'(DEPTH)));

    a_r6_quiet_in_fill: assert property (@(posedge clk) disable iff (rst)
        (clr_run && busy) |-> !st_valid);

    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (rst || (!busy && !st_valid)));
endmodule

bind strip_framebuffer sfb_checker #(.DEPTH(DEPTH), .AW(AW)) u_sfb_checker (
    .clk       (clk),
    .rst       (rst),
    .px_valid  (px_valid),
    .clr_start (clr_start),
    .busy      (busy),
    .st_valid  (st_valid),
    .st_data   (st_data),
    .st_index  (st_index),
    .st_ready  (st_ready)
);

// File: tb/strip_framebuffer_test.sv
module strip_framebuffer_test;
    localparam int DEPTH = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       px_valid = 1'b0;
    logic [6:0] px_x = '0;
    logic [5:0] px_y = '0;
    logic [1:0] px_op = '0;
    logic       clr_start = 1'b0;
    logic [7:0] clr_fill = '0;
    logic       busy;
    logic       st_valid;
    logic [7:0] st_data;
    logic [9:0] st_index;
    logic       st_ready = 1'b0;

    strip_framebuffer uut (
        .clk(clk), .rst(rst), .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
        .px_op(px_op), .clr_start(clr_start), .clr_fill(clr_fill), .busy(busy),
        .st_valid(st_valid), .st_data(st_data), .st_index(st_index), .st_ready(st_ready)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [9:0] idx;
        logic [7:0] val;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] model [DEPTH];
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    string      cur_tag = "R1";

    task automatic score(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // monitor: pops expected bytes on each handshake, checks hold behaviour
    bit         hold_prev = 1'b0;
    logic [7:0] prev_data;
    logic [9:0] prev_index;
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_prev && !busy) begin
                score(st_valid && st_data == prev_data && st_index == prev_index,
                      "R8", "held byte", {st_valid, st_index, st_data},
                      {1'b1, prev_index, prev_data});
            end
            if (st_valid && st_ready) begin
                if (exp_q.size() == 0) begin
                    score(1'b0, "R7", "unexpected stream byte", st_index, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    score(st_index == e.idx, "R7", "stream order", st_index, e.idx);
                    score(st_data == e.val, cur_tag, "stream byte", st_data, e.val);
                end
            end
            hold_prev  = st_valid && !st_ready;
            prev_data  = st_data;
            prev_index = st_index;
        end
    end

    task automatic push_range(input int start, input int count);
        for (int i = 0; i < count; i++) begin
            exp_t e;
            e.idx = 10'((start + i) % DEPTH);
            e.val = model[(start + i) % DEPTH];
            exp_q.push_back(e);
        end
    endtask

    function automatic void model_edit(input int x, input int y, input int op);
        int idx;
        logic [7:0] m;
        idx = (y / 8) * 128 + x;
        m = 8'(1) << (y % 8);
        case (op)
            0: model[idx] = model[idx] | m;
            1: model[idx] = model[idx] & ~m;
            2: model[idx] = model[idx] ^ m;
            default: ;
        endcase
    endfunction

    // pixel command; optionally offers a second, ignored command while busy
    task automatic pixel(input int x, input int y, input int op, input bit stray,
                         input int sx, input int sy);
        @(posedge clk); #1;
        px_valid = 1'b1; px_x = 7'(x); px_y = 6'(y); px_op = 2'(op);
        model_edit(x, y, op);
        @(posedge clk); #1;
        px_valid = 1'b0;
        score(busy == 1'b1, "R3", "busy in read cycle", busy, 1);
        if (stray) begin
            px_valid = 1'b1; px_x = 7'(sx); px_y = 6'(sy); px_op = 2'd0;
        end
        @(posedge clk); #1;
        px_valid = 1'b0;
        score(busy == 1'b1, "R3", "busy in write cycle", busy, 1);
        @(posedge clk); #1;
        score(busy == 1'b0, "R3", "idle after edit", busy, 0);
    endtask

    // fill; ends at the first idle cycle after the fill
    task automatic fill(input logic [7:0] val, input bit race_px, input bit stray_px,
                        input bit ready_after);
        int n;
        @(posedge clk); #1;
        clr_start = 1'b1; clr_fill = val;
        if (race_px) begin
            px_valid = 1'b1; px_x = 7'd60; px_y = 6'd60; px_op = 2'd2;
        end
        @(posedge clk); #1;
        clr_start = 1'b0; px_valid = 1'b0;
        if (ready_after) st_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) model[i] = val;
        n = 0;
        while (busy) begin
            n++;
            score(st_valid == 1'b0, "R6", "valid during fill", st_valid, 0);
            if (stray_px && n == 5) begin
                px_valid = 1'b1; px_x = 7'd50; px_y = 6'd20; px_op = 2'd2;
            end
            if (n == 6) px_valid = 1'b0;
            @(posedge clk); #1;
        end
        score(n == DEPTH, "R5", "fill busy cycles", n, DEPTH);
    endtask

    task automatic drain(input int limit);
        int k = 0;
        while (exp_q.size() != 0 && k < limit) begin
            @(posedge clk); #1;
            k++;
        end
        score(exp_q.size() == 0, "R7", "stream drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        score(1'b0, "R7", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        score(busy == 1'b0, "R10", "busy in reset", busy, 0);
        score(st_valid == 1'b0, "R10", "valid in reset", st_valid, 0);
        @(posedge clk); #1;
        rst = 1'b0;

        // blank fill with ready low, then stream restart at index 0 (R6)
        fill(8'h00, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        score(st_valid == 1'b1 && st_index == 10'd0, "R6", "first byte after fill",
              {st_valid, st_index}, {1'b1, 10'd0});
        score(st_data == 8'h00, "R5", "filled byte", st_data, 0);

        // R1 R2 R4 R3: pixel edits, none on byte 0
        pixel(5, 3, 0, 1'b0, 0, 0);
        pixel(5, 0, 0, 1'b0, 0, 0);
        pixel(5, 3, 2, 1'b0, 0, 0);
        pixel(127, 63, 0, 1'b0, 0, 0);
        pixel(10, 9, 0, 1'b0, 0, 0);
        pixel(10, 15, 0, 1'b0, 0, 0);
        pixel(10, 9, 1, 1'b0, 0, 0);
        pixel(10, 15, 3, 1'b0, 0, 0);
        pixel(64, 40, 0, 1'b1, 3, 3);

        // full frame plus wrap with a gappy ready (R1 R2 R3 R4 R7 R8)
        cur_tag = "R1 R2 R3 R4";
        push_range(0, DEPTH + 4);
        for (int i = 0; exp_q.size() != 0 && i < 8000; i++) begin
            @(posedge clk); #1;
            st_ready = (i % 4 != 3) && (i % 7 != 5);
        end
        st_ready = 1'b0;
        score(exp_q.size() == 0, "R7", "frame with wrap drained", exp_q.size(), 0);

        // R5: fill beats a same-cycle pixel command and ignores one during it;
        // R9: edit lands on the byte fetched in that cycle
        cur_tag = "R5 R9";
        fill(8'hA5, 1'b1, 1'b1, 1'b1);
        px_valid = 1'b1; px_x = 7'd2; px_y = 6'd0; px_op = 2'd2;
        model_edit(2, 0, 2);
        push_range(0, DEPTH);
        @(posedge clk); #1;
        px_valid = 1'b0;
        drain(4000);
        st_ready = 1'b0;
        score(model[2] == 8'hA4, "R9", "bench model of edited byte", model[2], 8'hA4);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule